// File: doc/BRIEF.md
# Conditional Jump Execution Unit

This unit carries out the two-word conditional jump of a 16-bit processor. A controller hands it the first instruction word, the address of that word, and the current 4-bit condition status, and pulses `start`. The first word holds an 8-bit opcode in bits 15:8, a 4-bit condition mask in bits 7:4 and a 4-bit index-register selector in bits 3:0. The unit reads the second word, which is the address operand, from the word after the instruction. It adds an index register if one is selected. For the indirect form it makes one more read to fetch the real target. It then decides whether to jump.

The decision ANDs the mask with the condition status bit by bit and ORs the four results together. Mask values 7 and F force the jump whatever the status. Status bit weights are 1 for less-than-zero, 2 for equal-to-zero, 4 for greater-than-zero and 8 for carry. At the end the unit pulses `done`. It presents either the target or the instruction address plus 2 on `ic_next`, with `ic_load` high. It writes nothing else.

Sequencing uses four named states. `ST_IDLE` waits for `start` and moves to `ST_FETCH_ADDR` for a legal opcode, or straight to `ST_UPDATE` for an illegal one. `ST_FETCH_ADDR` issues the operand read and waits for its valid strobe. From there it moves to `ST_INDIRECT_READ` for the indirect opcode or to `ST_UPDATE` for the direct one. `ST_INDIRECT_READ` issues the target read, waits for it, and moves to `ST_UPDATE`. `ST_UPDATE` lasts one cycle and returns to `ST_IDLE`.

Top module: `cond_jump_unit`

## Requirements
- R1: After reset, `done`, `ic_load`, `taken`, `illegal` and `mem_req` are all low.
- R2: The instruction word is split as opcode = bits 15:8, condition mask = bits 7:4, index selector = bits 3:0. The first memory read is made at the instruction address plus 1.
- R3: When the mask is neither 7 nor F, the jump is taken exactly when (mask AND status) has any bit set. The status weights are 1 = less than zero, 2 = equal to zero, 4 = greater than zero and 8 = carry.
- R4: Mask 7 or mask F takes the jump for every status value.
- R5: Mask 0 never jumps, and `ic_next` is the instruction address plus 2.
- R6: Index selector 0 adds nothing. A nonzero selector adds the 16-bit contents of that register to the address word, modulo 2^16.
- R7: Opcode 0x70 uses the formed address as the target and makes exactly one memory read.
- R8: Opcode 0x71 reads memory at the formed address and uses the word returned as the target. It makes exactly two memory reads.
- R9: Each read is a single-cycle `mem_req` pulse. No new request is raised until `mem_rvalid` has returned, whatever the latency.
- R10: `done` is high for exactly one cycle per instruction. `ic_load` is high only together with `done`. On a not-taken jump, `ic_next` is the instruction address plus 2.
- R11: Any opcode other than 0x70 or 0x71 raises `illegal` with `done`, keeps `ic_load` low and makes no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr_word` |
| instr_word | input | 16 | First instruction word |
| ic_in | input | 16 | Address of the first instruction word |
| cond_status | input | 4 | Condition status, sampled with `start` |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data |
| mem_rvalid | input | 1 | Read data valid strobe |
| rf_addr | output | 4 | Index register selector to the register file |
| rf_data | input | 16 | Index register contents |
| done | output | 1 | Completion pulse |
| ic_load | output | 1 | Write `ic_next` into the instruction counter |
| ic_next | output | 16 | New instruction counter value |
| taken | output | 1 | Jump was taken (valid with `done`) |
| illegal | output | 1 | Unrecognised opcode (valid with `done`) |

## Verification
The hardest situation to reach is an indexed indirect jump whose index addition wraps past 16 bits while memory answers slowly. A wrong wrap, a read from the wrong address or a second request raised before the first returns all show up only in this combined case. The bench's memory model takes a per-instruction latency, and the register model holds a near-full value in one register. Directed instructions combine that register with indirect opcodes and latencies from zero to several cycles. The bench counts requests and records each request address.

// File: rtl/cjmp_pkg.sv
package cjmp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH_ADDR,
        ST_INDIRECT_READ,
        ST_UPDATE
    } cj_state_e;

    localparam logic [7:0] OP_DIRECT   = 8'h70;
    localparam logic [7:0] OP_INDIRECT = 8'h71;
endpackage

// File: rtl/cjmp_cond_eval.sv
module cjmp_cond_eval #(
    parameter int CW = 4,
    parameter logic [CW-1:0] FORCE_A = 4'h7,
    parameter logic [CW-1:0] FORCE_B = 4'hF
) (
    input  logic [CW-1:0] mask,
    input  logic [CW-1:0] status,
    output logic          take
);
    logic hit;
    logic forced;

    always_comb begin
        hit    = |(mask & status);
        forced = (mask == FORCE_A) || (mask == FORCE_B);
        take   = hit || forced;
    end
endmodule

// File: rtl/cjmp_addr_gen.sv
module cjmp_addr_gen #(
    parameter int AW = 16,
    parameter int RW = 4
) (
    input  logic [AW-1:0] base,
    input  logic [RW-1:0] rx,
    input  logic [AW-1:0] rx_val,
    output logic [AW-1:0] ea
);
    logic [AW-1:0] offset;

    always_comb begin
        offset = (rx == '0) ? '0 : rx_val;
        ea     = base + offset;
    end
endmodule

// File: rtl/cond_jump_unit.sv
module cond_jump_unit
    import cjmp_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 4,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] instr_word,
    input  logic [AW-1:0] ic_in,
    input  logic [CW-1:0] cond_status,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    output logic [RW-1:0] rf_addr,
    input  logic [AW-1:0] rf_data,
    output logic          done,
    output logic          ic_load,
    output logic [AW-1:0] ic_next,
    output logic          taken,
    output logic          illegal
);
    localparam int OPW     = AW - CW - RW;
    localparam int OP_LSB  = CW + RW;
    localparam logic [AW-1:0] NEXT_STEP = AW'(2);
    localparam logic [AW-1:0] OPND_STEP = AW'(1);

    cj_state_e     state_q, state_d;
    logic [OPW-1:0] op_q;
    logic [CW-1:0]  mask_q;
    logic [RW-1:0]  rx_q;
    logic [AW-1:0]  ic_q;
    logic [CW-1:0]  cs_q;
    logic [AW-1:0]  ea_q;
    logic [AW-1:0]  target_q;
    logic           illegal_q;
    logic           issued_q;

    logic [OPW-1:0] op_in;
    logic           op_legal;
    logic           resp;
    logic [AW-1:0]  ea_w;
    logic           take_w;

    assign op_in    = instr_word[AW-1:OP_LSB];
    assign op_legal = (op_in == OPW'(OP_DIRECT)) || (op_in == OPW'(OP_INDIRECT));
    assign resp     = issued_q && mem_rvalid;

    cjmp_addr_gen #(.AW(AW), .RW(RW)) u_addr (
        .base   (mem_rdata),
        .rx     (rx_q),
        .rx_val (rf_data),
        .ea     (ea_w)
    );

    cjmp_cond_eval #(.CW(CW)) u_cond (
        .mask   (mask_q),
        .status (cs_q),
        .take   (take_w)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:          if (start) state_d = op_legal ? ST_FETCH_ADDR : ST_UPDATE;
            ST_FETCH_ADDR:    if (resp)  state_d = (op_q == OPW'(OP_INDIRECT)) ? ST_INDIRECT_READ
                                                                             : ST_UPDATE;
            ST_INDIRECT_READ: if (resp)  state_d = ST_UPDATE;
            ST_UPDATE:                   state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Captured instruction fields and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= '0;
            mask_q    <= '0;
            rx_q      <= '0;
            ic_q      <= '0;
            cs_q      <= '0;
            ea_q      <= '0;
            target_q  <= '0;
            illegal_q <= 1'b0;
            issued_q  <= 1'b0;
        end else begin
            if (mem_req)   issued_q <= 1'b1;
            else if (resp) issued_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q      <= op_in;
                    mask_q    <= instr_word[RW +: CW];
                    rx_q      <= instr_word[RW-1:0];
                    ic_q      <= ic_in;
                    cs_q      <= cond_status;
                    illegal_q <= !op_legal;
                end
                ST_FETCH_ADDR: if (resp) begin
                    ea_q     <= ea_w;
                    target_q <= ea_w;
                end
                ST_INDIRECT_READ: if (resp) target_q <= mem_rdata;
                ST_UPDATE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req  = ((state_q == ST_FETCH_ADDR) || (state_q == ST_INDIRECT_READ)) && !issued_q;
        mem_addr = (state_q == ST_FETCH_ADDR) ? ic_q + OPND_STEP : ea_q;
        rf_addr  = rx_q;
        done     = (state_q == ST_UPDATE);
        illegal  = done && illegal_q;
        ic_load  = done && !illegal_q;
        taken    = ic_load && take_w;
        ic_next  = taken ? target_q : ic_q + NEXT_STEP;
    end

    // Assertions
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> !done && !mem_req);

    assert_load_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ic_load |-> done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_illegal_no_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done && !ic_load && !taken);

    assert_illegal_no_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && !op_legal) |=> !mem_req);

    assert_forced_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_load && (mask_q == 4'h7 || mask_q == 4'hF)) |-> taken);

    assert_nop_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_load && mask_q == '0) |-> !taken && ic_next == ic_q + NEXT_STEP);

    assert_operand_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && state_q == ST_FETCH_ADDR) |-> mem_addr == ic_q + OPND_STEP);
endmodule

// File: tb/cond_jump_unit_bench.sv
module cond_jump_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr_word = '0;
    logic [15:0] ic_in = '0;
    logic [3:0]  cond_status = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic [3:0]  rf_addr;
    logic [15:0] rf_data;
    logic        done, ic_load, taken, illegal;
    logic [15:0] ic_next;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] mem [0:255];
    logic [15:0] regs [0:15];

    int          lat = 0;
    int          cnt = 0;
    logic        pend = 1'b0;
    logic [15:0] paddr = '0;
    int          nreq = 0;
    logic [15:0] first_addr = '0;
    logic [15:0] last_addr = '0;

    always #2.5 clk = ~clk;

    assign rf_data = regs[rf_addr];

    cond_jump_unit u_cond_jump_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_word(instr_word),
        .ic_in(ic_in), .cond_status(cond_status), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .rf_addr(rf_addr), .rf_data(rf_data), .done(done), .ic_load(ic_load),
        .ic_next(ic_next), .taken(taken), .illegal(illegal)
    );

    // Memory model with programmable latency
    always @(posedge clk) begin
        cycles <= cycles + 1;
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            if (nreq == 0) first_addr <= mem_addr;
            last_addr <= mem_addr;
            nreq  <= nreq + 1;
            pend  <= 1'b1;
            paddr <= mem_addr;
            cnt   <= lat;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[paddr[7:0]];
                pend       <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One instruction: issue, wait for done, check all results
    task automatic run_instr(input string req, input logic [7:0] op, input logic [3:0] c,
                             input logic [3:0] rx, input logic [15:0] opnd,
                             input logic [15:0] ic, input logic [3:0] cs, input int latency);
        logic [15:0] ea, tgt, exp_next;
        logic        legal, tk;
        int          w;
        legal = (op == 8'h70) || (op == 8'h71);
        mem[ic[7:0] + 8'd1] = opnd;
        ea  = opnd + ((rx == 4'd0) ? 16'd0 : regs[rx]);
        tgt = (op == 8'h71) ? mem[ea[7:0]] : ea;
        tk  = legal && ((|(c & cs)) || c == 4'h7 || c == 4'hF);
        exp_next = tk ? tgt : ic + 16'd2;
        @(negedge clk);
        lat = latency;
        nreq = 0;
        instr_word = {op, c, rx};
        ic_in = ic;
        cond_status = cs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 200) begin
            @(negedge clk);
            w++;
        end
        check({req, " done seen"}, 16'(done), 16'd1);
        check({req, " R11 illegal"}, 16'(illegal), 16'(!legal));
        check({req, " R10 ic_load"}, 16'(ic_load), 16'(legal));
        check({req, " taken"}, 16'(taken), 16'(tk));
        if (legal) check({req, " ic_next"}, ic_next, exp_next);
        check({req, " R7/R8 read count"}, 16'(nreq),
              legal ? ((op == 8'h71) ? 16'd2 : 16'd1) : 16'd0);
        if (legal) check({req, " R2 operand addr"}, first_addr, ic + 16'd1);
        if (op == 8'h71) check({req, " R8 indirect addr"}, last_addr, ea);
        @(negedge clk);
        check({req, " R10 done pulse"}, 16'(done), 16'd0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 done", 16'(done), 16'd0);
        check("R1 ic_load", 16'(ic_load), 16'd0);
        check("R1 taken", 16'(taken), 16'd0);
        check("R1 illegal", 16'(illegal), 16'd0);
        check("R1 mem_req", 16'(mem_req), 16'd0);
    endtask

    task automatic test_conditions();
        run_instr("R3 LT hit",        8'h70, 4'h1, 4'd0, 16'h0050, 16'h0010, 4'h1, 0);
        run_instr("R3 EQ miss",       8'h70, 4'h2, 4'd0, 16'h0050, 16'h0010, 4'h1, 0);
        run_instr("R3 carry GE hit",  8'h70, 4'hE, 4'd0, 16'h0060, 16'h0020, 4'h8, 1);
        run_instr("R3 GE miss",       8'h70, 4'h6, 4'd0, 16'h0060, 16'h0020, 4'h1, 0);
        run_instr("R3 NE hit",        8'h70, 4'h5, 4'd0, 16'h0070, 16'h0030, 4'h4, 2);
    endtask

    task automatic test_forced_and_nop();
        run_instr("R4 mask7",  8'h70, 4'h7, 4'd0, 16'h0080, 16'h0040, 4'h0, 0);
        run_instr("R4 maskF",  8'h70, 4'hF, 4'd0, 16'h0090, 16'h0040, 4'h0, 3);
        run_instr("R5 nop",    8'h70, 4'h0, 4'd0, 16'h00A0, 16'h0042, 4'hF, 0);
    endtask

    task automatic test_index();
        run_instr("R6 rx0 ignored", 8'h70, 4'h7, 4'd0, 16'h0020, 16'h0044, 4'h0, 0);
        run_instr("R6 rx3 add",     8'h70, 4'h7, 4'd3, 16'h0020, 16'h0046, 4'h0, 1);
        run_instr("R6 wrap",        8'h70, 4'h7, 4'd5, 16'h0020, 16'h0048, 4'h0, 0);
    endtask

    task automatic test_indirect();
        run_instr("R8 plain",         8'h71, 4'hF, 4'd0, 16'h00C0, 16'h004A, 4'h0, 0);
        run_instr("R8 indexed",       8'h71, 4'h2, 4'd2, 16'h00C0, 16'h004C, 4'h2, 2);
        run_instr("R9 wrap slow",     8'h71, 4'h7, 4'd5, 16'h00D0, 16'h004E, 4'h0, 6);
        run_instr("R8 not taken",     8'h71, 4'h8, 4'd0, 16'h00C0, 16'h0050, 4'h7, 4);
    endtask

    task automatic test_illegal();
        run_instr("R11 op72", 8'h72, 4'h7, 4'd0, 16'h00E0, 16'h0052, 4'hF, 0);
        run_instr("R11 op00", 8'h00, 4'hF, 4'd1, 16'h00E0, 16'h0054, 4'hF, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'hA000 ^ 16'(i * 7);
        for (int i = 0; i < 16; i++) regs[i] = 16'(i);
        regs[0] = 16'h1111;
        regs[3] = 16'h0010;
        regs[2] = 16'h0004;
        regs[5] = 16'hFFF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_conditions();
        test_forced_and_nop();
        test_index();
        test_indirect();
        test_illegal();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule